// File: doc/BRIEF.md
# TDM Audio Slot Serializer

This block places two audio samples on a shared serial data line that several devices can drive. A bit clock and a frame sync arrive from outside. Both are sampled in the system clock domain, which must run at least four times faster than the bit clock. A frame begins at a bit-clock rising edge at which the frame sync is seen high after it was low. After that edge the block counts falling edges of the bit clock and places a 16-bit slot for each channel at a programmable position.

Slot one begins a programmable number of bit clocks into the frame. Slot two follows the end of slot one after a gap. The gap uses slot one's offset by default. In split-offset mode it uses a second offset of its own. A two-bit enable field can leave either slot or both undriven. A swap control exchanges the samples between the two slots. The output-enable goes high only while a bit of an enabled slot is driven. With early release set, the line is freed half a bit clock before the slot ends, so the next talker has room to turn on.

All controls and both samples are captured at frame start, so every frame is sent with one consistent setting. A frame sync that arrives before the slots are complete cuts the current frame short and starts a new one.

Top module: `tdm_slot_serializer`

## Requirements
- R1: After reset `sd_oe` is 0 and stays 0 until the first frame start. The captured settings reset to: both offsets 0, split mode off, swap off, both slots enabled, early release on.
- R2: A frame starts at a bit-clock rise where `fsync` is 1 and was 0 at the previous rise. The falling edges that follow are numbered from 0, and slot one occupies falls `slot_off_a` through `slot_off_a`+15.
- R3: Each slot sends its 16-bit word most significant bit first, one bit per falling edge. `sdout` holds each bit until the next falling edge.
- R4: With `split_slots` = 0, slot two starts `slot_off_a` falls after slot one's last bit ends, at fall index 2·`slot_off_a`+16.
- R5: With `split_slots` = 1, slot two starts `slot_off_b` falls after slot one's last bit ends, at fall index `slot_off_a`+16+`slot_off_b`.
- R6: `chan_en` encoding: 00 enables both slots, 01 slot one only, 10 slot two only, 11 neither. A disabled slot leaves `sd_oe` at 0.
- R7: With `swap_lr` = 0, slot one carries `left_smp` and slot two carries `right_smp`. With `swap_lr` = 1, slot one carries `right_smp` and slot two carries `left_smp`.
- R8: With `early_release` = 1, `sd_oe` falls at the bit-clock rise inside the last bit of a slot. With it at 0, `sd_oe` stays high through that bit and falls at the next falling edge, unless another enabled slot begins there.
- R9: A frame start forces `sd_oe` to 0 and restarts the fall count, which truncates any slot still in progress.
- R10: Inputs that change after a frame start have no effect until the next frame start.
- R11: `sd_oe` is 0 at every fall index that lies outside an enabled slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Bit clock, synchronous to clk |
| fsync | input | 1 | Frame sync, sampled at bit-clock rises |
| left_smp | input | 16 | Left channel sample |
| right_smp | input | 16 | Right channel sample |
| slot_off_a | input | 8 | Slot one offset in bit clocks from frame start |
| slot_off_b | input | 8 | Gap after slot one when split mode is on |
| split_slots | input | 1 | Use `slot_off_b` for the second gap |
| swap_lr | input | 1 | Exchange samples between the slots |
| chan_en | input | 2 | Slot enable code |
| early_release | input | 1 | Release the line half a bit early |
| sdout | output | 1 | Serial data |
| sd_oe | output | 1 | Drive enable for the data line |

## Verification
The case that needs care is a frame start that falls on the same bit-clock rise as an early release, or in the middle of a slot, because truncation and the normal release then both act on `sd_oe` in one cycle. The bench makes this happen with frames deliberately shorter than their slots, and with frames whose next sync arrives exactly in the last bit of slot two. At that rise it expects `sd_oe` low. At the following falls it expects the new frame's slot positions and samples, computed from the values it captured at that frame start.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

    localparam int SAMPLE_BITS = 16;
    localparam int OFFSET_BITS = 8;

    typedef enum logic [1:0] {
        SLOT_NONE   = 2'd0,
        SLOT_FIRST  = 2'd1,
        SLOT_SECOND = 2'd2
    } slot_sel_e;

    typedef enum logic [1:0] {
        EN_BOTH  = 2'b00,
        EN_FIRST = 2'b01,
        EN_SECND = 2'b10,
        EN_NONE  = 2'b11
    } slot_en_e;

    typedef struct packed {
        logic     early;
        logic     swap;
        logic     split;
        slot_en_e en;
    } frame_ctl_t;

    localparam frame_ctl_t CTL_RESET = '{early: 1'b1, swap: 1'b0, split: 1'b0, en: EN_BOTH};

    // Longest reach of the second slot, in bit clocks after frame start.
    function automatic int frame_span(int sw, int ow);
        return 2 * ((1 << ow) - 1 + sw);
    endfunction

    function automatic logic slot_enabled(slot_en_e en, logic second);
        if (second)
            return (en == EN_BOTH) || (en == EN_SECND);
        return (en == EN_BOTH) || (en == EN_FIRST);
    endfunction

endpackage

// File: rtl/tdm_edge_detect.sv
module tdm_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic bclk,
    input  logic fsync,
    output logic bclk_rise,
    output logic bclk_fall,
    output logic frame_start
);
    logic bclk_q;
    logic fs_prev;

    assign bclk_rise   = bclk & ~bclk_q;
    assign bclk_fall   = ~bclk & bclk_q;
    assign frame_start = bclk_rise & fsync & ~fs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q  <= 1'b0;
            fs_prev <= 1'b0;
        end else begin
            bclk_q <= bclk;
            if (bclk_rise)
                fs_prev <= fsync;
        end
    end
endmodule

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer
    import tdm_ser_pkg::*;
#(
    parameter int SMP_W = SAMPLE_BITS,
    parameter int OFF_W = OFFSET_BITS,
    parameter int CNT_W = $clog2(frame_span(SAMPLE_BITS, OFFSET_BITS) + 2),
    parameter int IDX_W = $clog2(SAMPLE_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             bclk_fall,
    input  logic [OFF_W-1:0] off_a,
    input  logic [OFF_W-1:0] off_b,
    input  logic             split,
    output logic             active,
    output slot_sel_e        sel,
    output logic [IDX_W-1:0] bit_idx,
    output logic             last_bit
);
    localparam logic [CNT_W-1:0] SLOT_LEN = CNT_W'(SMP_W);
    localparam logic [CNT_W-1:0] LAST_REL = CNT_W'(SMP_W - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] s1, e1, s2, e2, gap, rel1, rel2, rel;
    logic             in1, in2;

    always_comb begin
        s1   = CNT_W'(off_a);
        e1   = s1 + SLOT_LEN;
        gap  = split ? CNT_W'(off_b) : CNT_W'(off_a);
        s2   = e1 + gap;
        e2   = s2 + SLOT_LEN;
        in1  = (cnt >= s1) && (cnt < e1);
        in2  = (cnt >= s2) && (cnt < e2);
        rel1 = cnt - s1;
        rel2 = cnt - s2;
        if (in1) begin
            sel = SLOT_FIRST;
            rel = rel1;
        end else if (in2) begin
            sel = SLOT_SECOND;
            rel = rel2;
        end else begin
            sel = SLOT_NONE;
            rel = '0;
        end
        bit_idx  = IDX_W'(SMP_W - 1) - IDX_W'(rel);
        last_bit = (sel != SLOT_NONE) && (rel == LAST_REL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (frame_start) begin
            cnt    <= '0;
            active <= 1'b1;
        end else if (bclk_fall && active && (cnt != '1)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tdm_shift_out.sv
module tdm_shift_out
    import tdm_ser_pkg::*;
#(
    parameter int SMP_W = SAMPLE_BITS,
    parameter int IDX_W = $clog2(SAMPLE_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bclk_rise,
    input  logic             bclk_fall,
    input  logic             frame_start,
    input  logic             active,
    input  slot_sel_e        sel,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             last_bit,
    input  frame_ctl_t       ctl,
    input  logic [SMP_W-1:0] left_w,
    input  logic [SMP_W-1:0] right_w,
    output logic             sdout,
    output logic             sd_oe
);
    logic [SMP_W-1:0] word1, word2;
    logic             en1, en2;
    logic             last_q;

    always_comb begin
        word1 = ctl.swap ? right_w : left_w;
        word2 = ctl.swap ? left_w  : right_w;
        en1   = slot_enabled(ctl.en, 1'b0);
        en2   = slot_enabled(ctl.en, 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sdout  <= 1'b0;
            sd_oe  <= 1'b0;
            last_q <= 1'b0;
        end else if (frame_start) begin
            sd_oe  <= 1'b0;
            last_q <= 1'b0;
        end else if (bclk_fall && active) begin
            if (sel == SLOT_FIRST && en1) begin
                sd_oe  <= 1'b1;
                sdout  <= word1[bit_idx];
                last_q <= last_bit;
            end else if (sel == SLOT_SECOND && en2) begin
                sd_oe  <= 1'b1;
                sdout  <= word2[bit_idx];
                last_q <= last_bit;
            end else begin
                sd_oe  <= 1'b0;
                last_q <= 1'b0;
            end
        end else if (bclk_rise && ctl.early && last_q) begin
            sd_oe  <= 1'b0;
            last_q <= 1'b0;
        end
    end
endmodule

// File: rtl/tdm_slot_serializer.sv
module tdm_slot_serializer
    import tdm_ser_pkg::*;
#(
    parameter int SMP_W = SAMPLE_BITS,
    parameter int OFF_W = OFFSET_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bclk,
    input  logic             fsync,
    input  logic [SMP_W-1:0] left_smp,
    input  logic [SMP_W-1:0] right_smp,
    input  logic [OFF_W-1:0] slot_off_a,
    input  logic [OFF_W-1:0] slot_off_b,
    input  logic             split_slots,
    input  logic             swap_lr,
    input  logic [1:0]       chan_en,
    input  logic             early_release,
    output logic             sdout,
    output logic             sd_oe
);
    localparam int CNT_W = $clog2(frame_span(SMP_W, OFF_W) + 2);
    localparam int IDX_W = $clog2(SMP_W);

    logic             bclk_rise, bclk_fall, frame_start;
    logic             active, last_bit;
    slot_sel_e        sel;
    logic [IDX_W-1:0] bit_idx;
    frame_ctl_t       ctl_q;
    logic [OFF_W-1:0] off_a_q, off_b_q;
    logic [SMP_W-1:0] left_q, right_q;

    tdm_edge_detect u_edge (
        .clk         (clk),
        .rst         (rst),
        .bclk        (bclk),
        .fsync       (fsync),
        .bclk_rise   (bclk_rise),
        .bclk_fall   (bclk_fall),
        .frame_start (frame_start)
    );

    // Settings and samples are captured together once per frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= CTL_RESET;
            off_a_q <= '0;
            off_b_q <= '0;
            left_q  <= '0;
            right_q <= '0;
        end else if (frame_start) begin
            ctl_q   <= '{early: early_release, swap: swap_lr,
                         split: split_slots, en: slot_en_e'(chan_en)};
            off_a_q <= slot_off_a;
            off_b_q <= slot_off_b;
            left_q  <= left_smp;
            right_q <= right_smp;
        end
    end

    tdm_slot_timer #(
        .SMP_W (SMP_W),
        .OFF_W (OFF_W),
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .bclk_fall   (bclk_fall),
        .off_a       (off_a_q),
        .off_b       (off_b_q),
        .split       (ctl_q.split),
        .active      (active),
        .sel         (sel),
        .bit_idx     (bit_idx),
        .last_bit    (last_bit)
    );

    tdm_shift_out #(
        .SMP_W (SMP_W),
        .IDX_W (IDX_W)
    ) u_out (
        .clk         (clk),
        .rst         (rst),
        .bclk_rise   (bclk_rise),
        .bclk_fall   (bclk_fall),
        .frame_start (frame_start),
        .active      (active),
        .sel         (sel),
        .bit_idx     (bit_idx),
        .last_bit    (last_bit),
        .ctl         (ctl_q),
        .left_w      (left_q),
        .right_w     (right_q),
        .sdout       (sdout),
        .sd_oe       (sd_oe)
    );
endmodule

// File: rtl/tdm_ser_checker.sv
module tdm_ser_checker (
    input logic       clk,
    input logic       rst,
    input logic       bclk,
    input logic       sdout,
    input logic       sd_oe,
    input logic       active,
    input logic       frame_start,
    input logic [1:0] en_code
);
    // R1: nothing is driven before the first frame start
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !active |-> !sd_oe);

    // R3: drive begins only after a falling bit-clock edge
    p_fall_launch_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sd_oe) |-> ($past(bclk) == 1'b0 && $past(bclk, 2) == 1'b1));

    // R3: data holds while driven, except right after a falling edge
    p_data_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (sd_oe && $past(sd_oe) && !($past(bclk) == 1'b0 && $past(bclk, 2) == 1'b1))
        |-> $stable(sdout));

    // R6: with both slots off the line is never driven
    p_all_off_r6: assert property (@(posedge clk) disable iff (rst)
        (en_code == 2'b11) |-> !sd_oe);

    // R8: release happens only on a bit-clock edge
    p_release_edge_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(sd_oe) |-> ($past(bclk) != $past(bclk, 2)));

    // R9: a frame start leaves the line released
    p_truncate_r9: assert property (@(posedge clk) disable iff (rst)
        $past(frame_start) |-> !sd_oe);
endmodule

bind tdm_slot_serializer tdm_ser_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .bclk        (bclk),
    .sdout       (sdout),
    .sd_oe       (sd_oe),
    .active      (active),
    .frame_start (frame_start),
    .en_code     (ctl_q.en)
);

// File: tb/tdm_slot_serializer_test.sv
module tdm_slot_serializer_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        bclk, fsync;
    logic [15:0] left_smp, right_smp;
    logic [7:0]  slot_off_a, slot_off_b;
    logic        split_slots, swap_lr, early_release;
    logic [1:0]  chan_en;
    logic        sdout, sd_oe;

    int vecs = 0;
    int errs = 0;
    bit done = 0;

    int          m_a, m_b;
    bit          m_split, m_swap, m_early;
    bit [1:0]    m_en;
    bit [15:0]   m_l, m_r;

    always #10 clk = ~clk;

    tdm_slot_serializer uut (
        .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync),
        .left_smp(left_smp), .right_smp(right_smp),
        .slot_off_a(slot_off_a), .slot_off_b(slot_off_b),
        .split_slots(split_slots), .swap_lr(swap_lr),
        .chan_en(chan_en), .early_release(early_release),
        .sdout(sdout), .sd_oe(sd_oe)
    );

    task automatic chk(bit eo, bit ed, string tag, int k);
        vecs++;
        if (sd_oe !== eo || (eo && sdout !== ed)) begin
            errs++;
            $display("FAIL %s at fall %0d: oe=%b data=%b, expected oe=%b data=%b",
                     tag, k, sd_oe, sdout, eo, ed);
        end
    endtask

    // Expected {oe, data} after fall k (high=0) or after the rise within bit k (high=1).
    function automatic bit [1:0] model(int k, bit high);
        int s1 = m_a;
        int e1 = s1 + 16;
        int s2 = e1 + (m_split ? m_b : m_a);
        int e2 = s2 + 16;
        bit en1 = (m_en == 2'b00) || (m_en == 2'b01);
        bit en2 = (m_en == 2'b00) || (m_en == 2'b10);
        bit [15:0] w1 = m_swap ? m_r : m_l;
        bit [15:0] w2 = m_swap ? m_l : m_r;
        if (k >= s1 && k < e1 && en1)
            return {!(high && m_early && k == e1 - 1), w1[15 - (k - s1)]};
        if (k >= s2 && k < e2 && en2)
            return {!(high && m_early && k == e2 - 1), w2[15 - (k - s2)]};
        return 2'b00;
    endfunction

    task automatic set_cfg(int a, int b, bit sp, bit sw, bit [1:0] en, bit er);
        slot_off_a = 8'(a); slot_off_b = 8'(b); split_slots = sp;
        swap_lr = sw; chan_en = en; early_release = er;
        left_smp = 16'($urandom); right_smp = 16'($urandom);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) begin
            bclk = 1'b1; fsync = 1'b0;
            @(negedge clk); chk(1'b0, 1'b0, tag, i); @(negedge clk);
            bclk = 1'b0;
            @(negedge clk); chk(1'b0, 1'b0, tag, i); @(negedge clk);
        end
    endtask

    // One frame of len bits; its last high phase is the next frame's start rise.
    task automatic frame(int len, string tag, bit mutate);
        bit [1:0] e;
        for (int k = 0; k < len; k++) begin
            bclk = 1'b1; fsync = (k == 0);
            if (k == 0) begin
                m_a = slot_off_a; m_b = slot_off_b; m_split = split_slots;
                m_swap = swap_lr; m_en = chan_en; m_early = early_release;
                m_l = left_smp; m_r = right_smp;
            end
            @(negedge clk);
            if (k == 0) chk(1'b0, 1'b0, {tag, "/R9 start"}, -1);
            else begin e = model(k - 1, 1'b1); chk(e[1], e[0], tag, k - 1); end
            @(negedge clk);
            if (mutate && k == 3) set_cfg($urandom % 8, $urandom % 8, ~split_slots,
                                          ~swap_lr, ~chan_en, ~early_release);
            bclk = 1'b0;
            @(negedge clk);
            e = model(k, 1'b0); chk(e[1], e[0], tag, k);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; bclk = 1'b0; fsync = 1'b0;
        set_cfg(0, 0, 0, 0, 2'b00, 1);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(1'b0, 1'b0, "R1 reset", -1);
        idle(4, "R1 idle");

        // R2 R3 R4 R8: defaults, slots back to back, early release on
        set_cfg(0, 9, 0, 0, 2'b00, 1);
        frame(40, "R2/R3/R4/R8", 0);
        // R4: shared offset used as the gap
        set_cfg(6, 0, 0, 0, 2'b00, 1);
        frame(52, "R4", 0);
        // R5 R8: split offsets, adjacent slots, early release off
        set_cfg(5, 0, 1, 0, 2'b00, 0);
        frame(45, "R5/R8", 0);
        // R5 R7: separate gap with swap
        set_cfg(3, 7, 1, 1, 2'b00, 1);
        frame(50, "R5/R7", 0);
        set_cfg(2, 4, 1, 1, 2'b00, 0);
        frame(42, "R7/R8", 0);
        // R6: each enable code
        set_cfg(1, 2, 1, 0, 2'b01, 1);
        frame(40, "R6 first only", 0);
        set_cfg(1, 2, 1, 1, 2'b10, 0);
        frame(40, "R6 second only", 0);
        set_cfg(1, 2, 1, 0, 2'b11, 1);
        frame(40, "R6 none", 0);
        // R9: truncation in slot one and exactly at slot two's last bit
        set_cfg(10, 0, 0, 0, 2'b00, 1);
        frame(20, "R9 mid slot", 0);
        set_cfg(0, 0, 1, 0, 2'b00, 1);
        frame(32, "R9 last bit", 0);
        set_cfg(0, 0, 1, 0, 2'b00, 0);
        frame(32, "R9 last bit late", 0);
        // R10: inputs changed mid-frame
        set_cfg(2, 3, 1, 0, 2'b00, 1);
        frame(45, "R10", 1);
        // Largest offsets reach the end of the count range
        set_cfg(255, 255, 1, 0, 2'b00, 1);
        frame(548, "R5/R11 max", 0);
        // R11: random settings and frame lengths
        for (int i = 0; i < 30; i++) begin
            set_cfg($urandom % 40, $urandom % 40, 1'($urandom), 1'($urandom),
                    2'($urandom), 1'($urandom));
            frame(2 + $urandom % 130, "R11 random", 0);
        end
        set_cfg(0, 0, 0, 0, 2'b11, 1);
        frame(4, "R11 tail", 0);
        finish_run();
    end
endmodule